// File: doc/BRIEF.md
# Debug Mailbox Channel

This block is a two-way, one-word-deep mailbox between a scan-chain debugger and software running on the processor core. Each direction has its own 32-bit word buffer and a flag that shows whether a word is waiting. The debugger reaches the mailbox through a small register port with a 5-bit address and a direction bit. The core reaches the same data and status through a simple read/write port.

A status word, readable from both sides, holds the two handshake flags, a sticky overrun flag and a 4-bit build-time version number in bits 31:28. Software uses the version number to identify the capability level. A data read by the debugger consumes the word the core posted. A status read never changes any state.

Flag polarity depends on direction. The debugger may write only while the inbound flag is 0. It may read only while the outbound flag is 1.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset, both handshake flags and the overrun flag are 0, both read-valid outputs are 0, and a status read returns the VERSION parameter in bits 31:28 with all other bits 0.
- R2: A debugger write (dir 1) to address 5 while bit 0 of the status word (the inbound flag) is 0 loads the inbound buffer and sets the inbound flag. A core data read (sel 0) returns that word and clears the inbound flag.
- R3: A debugger write to address 5 while the inbound flag is 1 is ignored. The buffer keeps its old word, and no status bit changes.
- R4: A core data write while bit 1 of the status word (the outbound flag) is 0 loads the outbound buffer and sets the outbound flag. A debugger read (dir 0) of address 5 returns that word and clears the outbound flag.
- R5: A core data write while the outbound flag is 1, with no debugger data read in the same cycle, is dropped. The old word stays, and bit 2 of the status word (overrun) sets and stays set until reset.
- R6: A status read, from the debugger at address 4 or from the core with sel 1, returns {VERSION, 25 zero bits, overrun, outbound, inbound} and changes no state.
- R7: A read request on either port gives its read-valid output and read data in the next cycle. Read-valid is 0 in any cycle that does not follow a read request.
- R8: Accesses from the two sides in the same cycle are all honoured, and when a set and a clear of one flag coincide, the set wins. A core write together with a debugger data read loads the new word, keeps the outbound flag at 1, leaves overrun unchanged, and gives the debugger the old word. A debugger write together with a core data read does the same for the inbound side.
- R9: A debugger data read while the outbound flag is 0 leaves it 0. Debugger reads of addresses other than 4 and 5 return 0. Debugger writes to any address other than 5, and core writes with sel 1, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| jt_req | input | 1 | Debugger access strobe |
| jt_wr | input | 1 | Debugger direction, 1 = write |
| jt_addr | input | 5 | Debugger register address (4 = status, 5 = data) |
| jt_wdata | input | 32 | Debugger write data |
| jt_rdata | output | 32 | Debugger read data, registered |
| jt_rvalid | output | 1 | Debugger read data valid |
| cp_req | input | 1 | Core access strobe |
| cp_wr | input | 1 | Core direction, 1 = write |
| cp_sel | input | 1 | Core register select, 0 = data, 1 = status |
| cp_wdata | input | 32 | Core write data |
| cp_rdata | output | 32 | Core read data, registered |
| cp_rvalid | output | 1 | Core read data valid |

## Verification
The assertions assume that each strobe is a clean single-cycle request qualified by its direction bit, and that no input is sampled during reset. Apart from this, the assertions do not depend on the two agents obeying the handshake rules. Several properties therefore target the misuse cases on purpose: writing to a full inbound buffer, writing to a full outbound buffer, and reading an empty one. The random stimulus drives every strobe fully each cycle. It weights the debugger address toward 4 and 5 with an occasional stray address. Directed sequences set up the same-cycle collisions in which a set meets a clear of the same flag.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;
  localparam int DATA_W   = 32;
  localparam int VER_W    = 4;
  localparam int BIT_IN   = 0;
  localparam int BIT_OUT  = 1;
  localparam int BIT_OVR  = 2;
  localparam int STAT_W   = 3;
  localparam int PAD_W    = DATA_W - VER_W - STAT_W;

  function automatic logic [DATA_W-1:0] status_word(
    input logic [VER_W-1:0] ver,
    input logic ovr,
    input logic out_full,
    input logic in_full
  );
    logic [DATA_W-1:0] w;
    w = {ver, {PAD_W{1'b0}}, {STAT_W{1'b0}}};
    w[BIT_IN]  = in_full;
    w[BIT_OUT] = out_full;
    w[BIT_OVR] = ovr;
    return w;
  endfunction
endpackage

// File: rtl/dbgm_slot.sv
module dbgm_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         full,
  output logic [W-1:0] data,
  output logic         drop
);
  logic accept;

  assign accept = push & (~full | pop);
  assign drop   = push & full & ~pop;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (accept) begin
        full <= 1'b1;
        data <= push_data;
      end else if (pop) begin
        full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dbgm_rdport.sv
module dbgm_rdport #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req,
  input  logic         sel_data,
  input  logic         sel_stat,
  input  logic [W-1:0] data_in,
  input  logic [W-1:0] stat_in,
  output logic [W-1:0] rdata,
  output logic         rvalid
);
  logic [W-1:0] mux;

  always_comb begin
    mux = '0;
    if (sel_data)      mux = data_in;
    else if (sel_stat) mux = stat_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= req;
      if (req) rdata <= mux;
    end
  end
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox #(
  parameter int                 ADDR_W    = 5,
  parameter logic [ADDR_W-1:0]  STAT_ADDR = 5'd4,
  parameter logic [ADDR_W-1:0]  DATA_ADDR = 5'd5,
  parameter logic [3:0]         VERSION   = 4'd6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        jt_req,
  input  logic        jt_wr,
  input  logic [4:0]  jt_addr,
  input  logic [31:0] jt_wdata,
  output logic [31:0] jt_rdata,
  output logic        jt_rvalid,
  input  logic        cp_req,
  input  logic        cp_wr,
  input  logic        cp_sel,
  input  logic [31:0] cp_wdata,
  output logic [31:0] cp_rdata,
  output logic        cp_rvalid
);
  import dbgm_pkg::*;

  logic jt_rd, jt_hit_data, jt_hit_stat;
  logic cp_rd;
  logic in_push, in_pop, in_full, in_drop;
  logic out_push, out_pop, out_full, out_drop;
  logic ovr_q;
  logic [DATA_W-1:0] in_data, out_data, stat;

  assign jt_rd       = jt_req & ~jt_wr;
  assign jt_hit_data = (jt_addr == DATA_ADDR);
  assign jt_hit_stat = (jt_addr == STAT_ADDR);
  assign cp_rd       = cp_req & ~cp_wr;

  assign in_push  = jt_req & jt_wr & jt_hit_data;
  assign in_pop   = cp_rd & ~cp_sel;
  assign out_push = cp_req & cp_wr & ~cp_sel;
  assign out_pop  = jt_rd & jt_hit_data;

  dbgm_slot #(.W(DATA_W)) u_in_slot (
    .clk(clk), .rst(rst), .push(in_push), .push_data(jt_wdata),
    .pop(in_pop), .full(in_full), .data(in_data), .drop(in_drop)
  );

  dbgm_slot #(.W(DATA_W)) u_out_slot (
    .clk(clk), .rst(rst), .push(out_push), .push_data(cp_wdata),
    .pop(out_pop), .full(out_full), .data(out_data), .drop(out_drop)
  );

  always_ff @(posedge clk) begin
    if (rst) ovr_q <= 1'b0;
    else if (out_drop) ovr_q <= 1'b1;
  end

  assign stat = status_word(VERSION, ovr_q, out_full, in_full);

  dbgm_rdport #(.W(DATA_W)) u_jt_rd (
    .clk(clk), .rst(rst), .req(jt_rd), .sel_data(jt_hit_data),
    .sel_stat(jt_hit_stat), .data_in(out_data), .stat_in(stat),
    .rdata(jt_rdata), .rvalid(jt_rvalid)
  );

  dbgm_rdport #(.W(DATA_W)) u_cp_rd (
    .clk(clk), .rst(rst), .req(cp_rd), .sel_data(~cp_sel),
    .sel_stat(cp_sel), .data_in(in_data), .stat_in(stat),
    .rdata(cp_rdata), .rvalid(cp_rvalid)
  );

  logic unused_in_drop;
  assign unused_in_drop = in_drop;
endmodule

// File: rtl/dbgm_mailbox_chk.sv
module dbgm_mailbox_chk #(
  parameter logic [4:0] STAT_ADDR = 5'd4,
  parameter logic [4:0] DATA_ADDR = 5'd5,
  parameter logic [3:0] VERSION   = 4'd6
) (
  input logic       clk,
  input logic       rst,
  input logic       jt_req,
  input logic       jt_wr,
  input logic [4:0] jt_addr,
  input logic [3:0] jt_ver,
  input logic       jt_rvalid,
  input logic       cp_req,
  input logic       cp_wr,
  input logic       cp_sel,
  input logic       in_flag,
  input logic       out_flag,
  input logic       ovr_flag
);
  p_in_set_r2: assert property (@(posedge clk) disable iff (rst)
    (jt_req && jt_wr && jt_addr == DATA_ADDR && !in_flag) |=> in_flag);

  p_in_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (jt_req && jt_wr && jt_addr == DATA_ADDR && in_flag && !(cp_req && !cp_wr && !cp_sel)) |=> in_flag);

  p_out_set_r4: assert property (@(posedge clk) disable iff (rst)
    (cp_req && cp_wr && !cp_sel && !out_flag) |=> out_flag);

  p_ovr_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    ovr_flag |=> ovr_flag);

  p_ovr_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_flag) |-> $past(cp_req && cp_wr && !cp_sel && out_flag));

  p_stat_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (jt_req && !jt_wr && jt_addr == STAT_ADDR && !cp_req)
    |=> ($stable(in_flag) && $stable(out_flag) && $stable(ovr_flag)));

  p_rvalid_next_r7: assert property (@(posedge clk) disable iff (rst)
    (jt_req && !jt_wr) |=> jt_rvalid);

  p_rvalid_only_r7: assert property (@(posedge clk) disable iff (rst)
    jt_rvalid |-> $past(jt_req && !jt_wr));

  p_version_r1: assert property (@(posedge clk) disable iff (rst)
    (jt_rvalid && $past(jt_addr) == STAT_ADDR) |-> jt_ver == VERSION);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (cp_req && cp_wr && !cp_sel && out_flag && jt_req && !jt_wr && jt_addr == DATA_ADDR)
    |=> (out_flag && $stable(ovr_flag)));
endmodule

bind dbg_mailbox dbgm_mailbox_chk #(
  .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR), .VERSION(VERSION)
) u_chk (
  .clk(clk), .rst(rst), .jt_req(jt_req), .jt_wr(jt_wr), .jt_addr(jt_addr),
  .jt_ver(jt_rdata[31:28]), .jt_rvalid(jt_rvalid), .cp_req(cp_req),
  .cp_wr(cp_wr), .cp_sel(cp_sel), .in_flag(in_full), .out_flag(out_full),
  .ovr_flag(ovr_q)
);

// File: tb/dbg_mailbox_test.sv
`timescale 1ns/1ps
module dbg_mailbox_test;
  localparam logic [3:0] VER = 4'd6;

  logic        clk = 1'b0;
  logic        rst;
  logic        jt_req, jt_wr, cp_req, cp_wr, cp_sel;
  logic [4:0]  jt_addr;
  logic [31:0] jt_wdata, cp_wdata, jt_rdata, cp_rdata;
  logic        jt_rvalid, cp_rvalid;

  int checks = 0;
  int bad    = 0;

  logic        m_in, m_out, m_ovr;
  logic [31:0] m_in_d, m_out_d;

  always #10 clk = ~clk;

  dbg_mailbox #(.VERSION(VER)) uut (
    .clk(clk), .rst(rst), .jt_req(jt_req), .jt_wr(jt_wr), .jt_addr(jt_addr),
    .jt_wdata(jt_wdata), .jt_rdata(jt_rdata), .jt_rvalid(jt_rvalid),
    .cp_req(cp_req), .cp_wr(cp_wr), .cp_sel(cp_sel), .cp_wdata(cp_wdata),
    .cp_rdata(cp_rdata), .cp_rvalid(cp_rvalid)
  );

  function automatic logic [31:0] exp_stat();
    return {VER, 25'd0, m_ovr, m_out, m_in};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag,
                      input logic jq, input logic jw, input logic [4:0] ja, input logic [31:0] jd,
                      input logic cq, input logic cw, input logic cs, input logic [31:0] cd);
    logic [31:0] ej, ec;
    logic jrd, crd, cpush, jpop, jpush, cpop;
    @(negedge clk);
    jt_req = jq; jt_wr = jw; jt_addr = ja; jt_wdata = jd;
    cp_req = cq; cp_wr = cw; cp_sel = cs; cp_wdata = cd;
    jrd = jq & ~jw;
    crd = cq & ~cw;
    ej = (ja == 5'd5) ? m_out_d : ((ja == 5'd4) ? exp_stat() : 32'd0);
    ec = cs ? exp_stat() : m_in_d;
    @(posedge clk);
    #1;
    chk(tag, {31'd0, jt_rvalid}, {31'd0, jrd});
    chk(tag, {31'd0, cp_rvalid}, {31'd0, crd});
    if (jrd) chk(tag, jt_rdata, ej);
    if (crd) chk(tag, cp_rdata, ec);
    cpush = cq & cw & ~cs;
    jpop  = jrd & (ja == 5'd5);
    jpush = jq & jw & (ja == 5'd5);
    cpop  = crd & ~cs;
    if (cpush && (!m_out || jpop)) begin
      m_out_d = cd; m_out = 1'b1;
    end else begin
      if (cpush) m_ovr = 1'b1;
      if (jpop)  m_out = 1'b0;
    end
    if (jpush && (!m_in || cpop)) begin
      m_in_d = jd; m_in = 1'b1;
    end else if (cpop) begin
      m_in = 1'b0;
    end
  endtask

  task automatic idle();
    step("idle", 0, 0, 5'd0, 32'd0, 0, 0, 0, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R7 act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int seed;
    rst = 1'b1;
    jt_req = 0; jt_wr = 0; jt_addr = 0; jt_wdata = 0;
    cp_req = 0; cp_wr = 0; cp_sel = 0; cp_wdata = 0;
    m_in = 0; m_out = 0; m_ovr = 0; m_in_d = 0; m_out_d = 0;
    seed = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 rvalid", {31'd0, jt_rvalid}, 32'd0);
    chk("R1 cp_rvalid", {31'd0, cp_rvalid}, 32'd0);
    step("R1", 1, 0, 5'd4, 0, 1, 0, 1, 0);

    step("R2 write", 1, 1, 5'd5, 32'hA5A5_0001, 0, 0, 0, 0);
    step("R6 stat", 1, 0, 5'd4, 0, 1, 0, 1, 0);
    step("R3 full write", 1, 1, 5'd5, 32'hDEAD_BEEF, 0, 0, 0, 0);
    step("R2 core read", 0, 0, 5'd0, 0, 1, 0, 0, 0);
    step("R2 flag clear", 1, 0, 5'd4, 0, 0, 0, 0, 0);

    step("R9 empty read", 1, 0, 5'd5, 0, 0, 0, 0, 0);
    step("R9 stray addr", 1, 1, 5'd9, 32'h1111_2222, 1, 1, 1, 32'hFFFF_FFFF);
    step("R9 stray read", 1, 0, 5'd9, 0, 1, 0, 1, 0);

    step("R4 core write", 0, 0, 5'd0, 0, 1, 1, 0, 32'h1234_5678);
    step("R5 overrun", 0, 0, 5'd0, 0, 1, 1, 0, 32'h8765_4321);
    step("R5 stat", 1, 0, 5'd4, 0, 0, 0, 0, 0);
    step("R4 dbg read", 1, 0, 5'd5, 0, 0, 0, 0, 0);
    step("R5 sticky", 1, 0, 5'd4, 0, 1, 0, 1, 0);

    step("R8 setup", 0, 0, 5'd0, 0, 1, 1, 0, 32'h0000_00AA);
    step("R8 out collide", 1, 0, 5'd5, 0, 1, 1, 0, 32'h0000_00BB);
    step("R8 stat", 1, 0, 5'd4, 0, 0, 0, 0, 0);
    step("R8 new word", 1, 0, 5'd5, 0, 0, 0, 0, 0);
    step("R8 in setup", 1, 1, 5'd5, 32'h0000_0CC0, 0, 0, 0, 0);
    step("R8 in collide", 1, 1, 5'd5, 32'h0000_0DD0, 1, 0, 0, 0);
    step("R8 in new", 1, 0, 5'd4, 0, 1, 0, 0, 0);
    step("R7 idle", 0, 0, 5'd0, 0, 0, 0, 0, 0);

    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_in = 0; m_out = 0; m_ovr = 0; m_in_d = 0; m_out_d = 0;
    step("R1 after reset", 1, 0, 5'd4, 0, 1, 0, 1, 0);

    for (int i = 0; i < 600; i++) begin
      logic [4:0] a;
      int pick;
      pick = $urandom_range(0, 9);
      a = (pick < 5) ? 5'd5 : ((pick < 9) ? 5'd4 : 5'($urandom_range(0, 31)));
      step("R2 R4 R8 random",
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, $urandom,
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 3) == 0), $urandom);
    end
    idle();

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule